// File: doc/BRIEF.md
# Routable Periodic Interrupt Timer

This block is a register-programmed down-counter that raises a periodic interrupt and steers it to one core of a small cluster. Each core can take the interrupt on its normal or on its fast interrupt line. Software programs a 28-bit period and turns on counting and interrupt delivery through a control/status register. A separate input strobe advances the count by one at a fixed rate. When the programmed number of strobes has arrived, a pending flag is set and the counter reloads itself, so the next period starts with no software action.

Software clears the pending flag through an acknowledge register that cannot be read back. The same write can also restart the current period from the top. A small routing register picks the destination core and the line type. Only one of the eight interrupt outputs can be high at a time. It stays high while the flag and the interrupt enable are both set.

Register access is a single-cycle write strobe with a byte address. Read data is a combinational decode of the presented address.

Top module: `periodic_route_timer`

## Requirements
- R1: After reset, the routing register and the control register both read 0, all interrupt outputs are low, and strobes cause no expiry until the timer is enabled.
- R2: The routing register sits at byte offset 0x24 and keeps only bits 2:0; other bits read as 0. The acknowledge register sits at 0x38 and always reads 0. The control register sits at 0x34 and reads as {pending[31], reload[30], int_enable[29], enable[28], period[27:0]}.
- R3: A control write with bit 28 set loads the counter with the written period at that write's clock edge. A strobe in the write cycle is not counted. The pending flag becomes visible in read data right after the edge that takes the N-th following strobe, and not earlier.
- R4: At each expiry the counter restarts from the period, so the flag sets again after another N strobes without any new control write.
- R5: An acknowledge write with bit 31 set clears the pending flag at its edge. An expiry in the same cycle wins and leaves the flag set.
- R6: An acknowledge write with bit 30 set restarts the period while the timer is enabled. The strobe in that cycle is not counted.
- R7: A control write with bit 28 clear stops counting, and no further expiry occurs.
- R8: A period of 0 never expires, whatever the number of strobes.
- R9: The interrupt is active only while int_enable and pending are both set. Each output is registered and follows the flag, the enable or the route one clock later.
- R10: Routing bits 1:0 select the core. Bit 2 set drives that core's FIQ output, and bit 2 clear drives its IRQ output. At most one output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Single-cycle count strobe at the timer rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | NUM_CORES | Normal interrupt line per core |
| fiq_o | output | NUM_CORES | Fast interrupt line per core |

## Verification
A write and a strobe act at the same clock edge. The flag is therefore readable right after the edge that takes the N-th strobe, and the interrupt outputs change one edge after that. The bench drives every stimulus on the falling edge and checks read data half a cycle after the edge that caused the change. It checks the outputs one full cycle later, and also checks in the cycle between that they are still low. The same latency rules apply across the sweep of periods and all eight route codes, to acknowledge-restart and to route changes while the interrupt is asserted.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int VAL_W = 28;

  localparam logic [7:0] OFS_ROUTE = 8'h24;
  localparam logic [7:0] OFS_CTRL  = 8'h34;
  localparam logic [7:0] OFS_ACK   = 8'h38;

  localparam int B_PEND = 31;
  localparam int B_RLD  = 30;
  localparam int B_IE   = 29;
  localparam int B_EN   = 28;

  typedef struct packed {
    logic             pend;
    logic             rld;
    logic             ie;
    logic             en;
    logic [VAL_W-1:0] period;
  } ctrl_t;
endpackage

// File: rtl/prt_regs.sv
module prt_regs
  import prt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              expire,
  output logic [31:0]       rdata,
  output ctrl_t             ctrl,
  output logic [RT_W-1:0]   route,
  output logic              cnt_load,
  output logic              cnt_hold,
  output logic [VAL_W-1:0]  ld_val
);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFS_ROUTE);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);

  ctrl_t           ctrl_q, ctrl_nx;
  logic [RT_W-1:0] route_q, route_nx;
  logic            ctrl_wr, ack_wr, route_wr;

  assign route_wr = wr && (addr == A_ROUTE);
  assign ctrl_wr  = wr && (addr == A_CTRL);
  assign ack_wr   = wr && (addr == A_ACK);

  always_comb begin
    route_nx = route_q;
    if (route_wr) route_nx = wdata[RT_W-1:0];
  end

  always_comb begin
    ctrl_nx = ctrl_q;
    if (ctrl_wr) ctrl_nx = ctrl_t'(wdata);
    if (ack_wr && wdata[B_PEND]) ctrl_nx.pend = 1'b0;
    if (expire) ctrl_nx.pend = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      route_q <= '0;
    end else begin
      ctrl_q  <= ctrl_nx;
      route_q <= route_nx;
    end
  end

  assign cnt_load = (ctrl_wr && wdata[B_EN]) || (ack_wr && wdata[B_RLD] && ctrl_q.en);
  assign cnt_hold = ctrl_wr;
  assign ld_val   = ctrl_wr ? wdata[VAL_W-1:0] : ctrl_q.period;

  always_comb begin
    rdata = '0;
    if (addr == A_ROUTE) rdata[RT_W-1:0] = route_q;
    else if (addr == A_CTRL) rdata = ctrl_q;
  end

  assign ctrl  = ctrl_q;
  assign route = route_q;

  p_expiry_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ctrl_q.pend);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && wdata[B_PEND] && !expire) |=> !ctrl_q.pend);
endmodule

// File: rtl/prt_counter.sv
module prt_counter
  import prt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [VAL_W-1:0] period,
  input  logic             load,
  input  logic             hold,
  input  logic [VAL_W-1:0] ld_val,
  output logic             expire
);
  logic [VAL_W-1:0] cnt_q, cnt_nx;
  logic             step;

  assign step   = !load && !hold && en && tick && (cnt_q != '0);
  assign expire = step && (cnt_q == VAL_W'(1));

  always_comb begin
    cnt_nx = cnt_q;
    if (load) cnt_nx = ld_val;
    else if (expire) cnt_nx = period;
    else if (step) cnt_nx = cnt_q - VAL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  p_cnt_within_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= period));

  p_stopped_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt_q));

  p_zero_never_expires_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0 && !load) |-> !expire);
endmodule

// File: rtl/prt_route.sv
module prt_route #(
  parameter int NUM_CORES = 4,
  parameter int RT_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic [RT_W-1:0]      route,
  output logic [NUM_CORES-1:0] irq_o,
  output logic [NUM_CORES-1:0] fiq_o
);
  localparam int CORE_W = RT_W - 1;

  logic [NUM_CORES-1:0] irq_nx, fiq_nx, irq_q, fiq_q;
  logic                 to_fiq;
  logic [CORE_W-1:0]    core;

  assign to_fiq = route[CORE_W];
  assign core   = route[CORE_W-1:0];

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    logic hit;
    assign hit       = active && (core == CORE_W'(k));
    assign irq_nx[k] = hit && !to_fiq;
    assign fiq_nx[k] = hit && to_fiq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      fiq_q <= '0;
    end else begin
      irq_q <= irq_nx;
      fiq_q <= fiq_nx;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  p_single_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, fiq_q}));

  p_needs_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|{irq_q, fiq_q}) |-> $past(active));
endmodule

// File: rtl/periodic_route_timer.sv
module periodic_route_timer
  import prt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_tick,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_CORES-1:0] irq_o,
  output logic [NUM_CORES-1:0] fiq_o
);
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int RT_W   = CORE_W + 1;

  logic             rst_s1, rst_s2;
  ctrl_t            ctrl;
  logic [RT_W-1:0]  route;
  logic             cnt_load, cnt_hold, expire;
  logic [VAL_W-1:0] ld_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  prt_regs #(.ADDR_W(ADDR_W), .RT_W(RT_W)) u_regs (
    .clk(clk), .rst_n(rst_s2), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .expire(expire), .rdata(reg_rdata), .ctrl(ctrl), .route(route),
    .cnt_load(cnt_load), .cnt_hold(cnt_hold), .ld_val(ld_val)
  );

  prt_counter u_counter (
    .clk(clk), .rst_n(rst_s2), .tick(cnt_tick), .en(ctrl.en),
    .period(ctrl.period), .load(cnt_load), .hold(cnt_hold), .ld_val(ld_val),
    .expire(expire)
  );

  prt_route #(.NUM_CORES(NUM_CORES), .RT_W(RT_W)) u_route (
    .clk(clk), .rst_n(rst_s2), .active(ctrl.ie && ctrl.pend), .route(route),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );
endmodule

// File: tb/periodic_route_timer_bench.sv
module periodic_route_timer_bench;
  localparam logic [7:0] A_RT = 8'h24, A_CT = 8'h34, A_AK = 8'h38;
  localparam logic [31:0] EN = 32'h1000_0000, IE = 32'h2000_0000;
  localparam logic [31:0] RLD = 32'h4000_0000, PND = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0, cnt_tick = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  irq_o, fiq_o;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  periodic_route_timer u_periodic_route_timer (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_tick = 1'b1;
      @(negedge clk);
    end
    cnt_tick = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic pend(input string req, input logic exp);
    reg_addr = A_CT; #1;
    check(req, {31'b0, reg_rdata[31]}, {31'b0, exp});
  endtask

  function automatic logic [7:0] outs_for(input logic [2:0] r);
    logic [7:0] v = '0;
    v[{r[2], r[1:0]}] = 1'b1;
    return v;
  endfunction

  task automatic outs(input string req, input logic [7:0] exp);
    check(req, {24'b0, fiq_o, irq_o}, {24'b0, exp});
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd("R1 route", A_RT, 0);
    rd("R1 ctrl", A_CT, 0);
    outs("R1 outs", 8'h00);
    ticks(20);
    pend("R1 no expiry while off", 1'b0);
    // R2 register map
    wr(A_RT, 32'hFFFF_FFFF);
    rd("R2 route bits 2:0 only", A_RT, 32'h7);
    rd("R2 ack reads zero", A_AK, 0);
    wr(A_CT, RLD | 32'h0ABC_DEF);
    rd("R2 ctrl layout", A_CT, RLD | 32'h0ABC_DEF);
    wr(A_CT, 0);

    // R3 R4 R5 R9 R10 sweep over periods and route codes
    for (int p = 1; p <= 5; p++) begin
      for (int r = 0; r < 8; r++) begin
        wr(A_RT, r);
        cnt_tick = 1'b1;
        wr(A_CT, EN | IE | p);        // strobe during write is not counted (R3)
        cnt_tick = 1'b0;
        if (p > 1) begin ticks(p - 1); pend("R3 not before N", 1'b0); end
        ticks(1);
        pend("R3 flag at N", 1'b1);
        outs("R9 output one cycle later", 8'h00);
        @(negedge clk);
        outs("R10 routed line", outs_for(3'(r)));
        wr(A_AK, PND);
        pend("R5 ack clears", 1'b0);
        @(negedge clk);
        outs("R9 output drops", 8'h00);
        if (p > 1) begin ticks(p - 1); pend("R4 not before next N", 1'b0); end
        ticks(1);
        pend("R4 auto reload expiry", 1'b1);
        wr(A_AK, PND);
      end
    end

    // R5 expiry in the ack cycle wins
    wr(A_CT, EN | IE | 2);
    ticks(1);
    cnt_tick = 1'b1;
    wr(A_AK, PND);
    cnt_tick = 1'b0;
    pend("R5 expiry beats ack", 1'b1);
    wr(A_AK, PND);

    // R9 int_enable clear masks outputs but flag still sets
    wr(A_RT, 3'd5);
    wr(A_CT, EN | 3);
    ticks(3);
    pend("R9 flag without ie", 1'b1);
    @(negedge clk); @(negedge clk);
    outs("R9 masked", 8'h00);
    wr(A_CT, EN | IE | PND | 3);
    @(negedge clk);
    outs("R9 ie set routes", outs_for(3'd5));
    // R10 route change moves output one cycle later
    wr(A_RT, 3'd2);
    outs("R10 old route held", outs_for(3'd5));
    @(negedge clk);
    outs("R10 new route", outs_for(3'd2));
    wr(A_AK, PND);

    // R6 acknowledge restart
    wr(A_CT, EN | IE | 4);
    ticks(3);
    cnt_tick = 1'b1;
    wr(A_AK, RLD);
    cnt_tick = 1'b0;
    ticks(3);
    pend("R6 restart delays expiry", 1'b0);
    ticks(1);
    pend("R6 expiry after restart", 1'b1);
    wr(A_AK, PND);

    // R7 stop
    wr(A_CT, IE | 2);
    ticks(10);
    pend("R7 stopped", 1'b0);
    wr(A_AK, RLD);
    ticks(10);
    pend("R6 restart ignored when off", 1'b0);

    // R8 zero period
    wr(A_CT, EN | IE);
    ticks(300);
    pend("R8 zero never expires", 1'b0);
    outs("R8 outs low", 8'h00);

    // R1 reset mid run
    wr(A_RT, 3'd6);
    wr(A_CT, EN | IE | PND | 7);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R1 ctrl after reset", A_CT, 0);
    rd("R1 route after reset", A_RT, 0);
    outs("R1 outs after reset", 8'h00);
    finish_run();
  end
endmodule